// File: doc/BRIEF.md
# Activity/Inactivity Link-Loop Controller

This block decides how the activity and inactivity detectors of a motion sensor work together. It takes per-axis enables for each detector class, one trigger pulse from each detector, a 2-bit processing-mode field, an autosleep control bit and a strobe that marks a host read of the status register. From these it drives arm signals for the two detectors, the activity and inactivity interrupt flags, and a request to enter the low-power wake-up mode. The threshold comparators, the filters and the wake-up timer sit outside the block.

In the free-running mode both detectors watch the signal at once, and each flag stays set until the host reads status. In the linked mode the detectors take turns, starting with activity, and the host read both clears the flag and passes control to the other detector. In the looped mode the detectors also take turns, but each flag lasts a single cycle and clears itself. A linked or looped setting only takes effect when at least one activity axis and at least one inactivity axis are enabled. Autosleep acts only in the two alternating modes.

Top module: `actlink_ctrl`

## Requirements
- R1: After reset both flags and the wake-up request are 0 and the block runs in the free-running mode, with each arm output equal to the OR of its own axis enables.
- R2: In the free-running mode (field 00) each detector is armed when any of its axes is enabled. A trigger on an armed detector sets its flag at the next clock edge. The flag holds until a cycle with the status strobe high. A trigger in the same cycle as the strobe leaves that flag set.
- R3: In the linked mode (field 01) exactly one detector is armed, activity first. Triggers on the unarmed detector are ignored, and so are further triggers while a flag is pending. The flag holds until the status strobe. That strobe clears the flag and arms the other detector at the same clock edge.
- R4: In the looped mode (field 10) an accepted trigger raises its flag for exactly one cycle, with neither detector armed in that cycle. On the following cycle the opposite detector is armed. The status strobe has no effect in this mode.
- R5: Field values 01 and 10 fall back to the free-running behaviour when no activity axis or no inactivity axis is enabled.
- R6: Field value 11 behaves as the free-running mode.
- R7: With autosleep set in the linked or looped mode, an accepted inactivity trigger sets the wake-up request at the same edge as its flag, and an accepted activity trigger clears it.
- R8: In the free-running mode autosleep is ignored and the wake-up request stays 0. Clearing autosleep drops the request at the next clock edge.
- R9: Whenever the effective mode changes, the block spends one cycle in which triggers are ignored. At the end of that cycle both flags and the wake-up request are cleared and the activity detector is the one armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| act_axis_en | input | NAXES | Per-axis enables of the activity detector |
| inact_axis_en | input | NAXES | Per-axis enables of the inactivity detector |
| act_hit | input | 1 | Activity detector trigger pulse |
| inact_hit | input | 1 | Inactivity detector trigger pulse |
| proc_mode | input | 2 | Processing mode: 00 free-running, 01 linked, 10 looped, 11 free-running |
| autosleep | input | 1 | Autosleep enable |
| status_rd | input | 1 | Strobe: host read of status |
| act_armed | output | 1 | Activity detector armed |
| inact_armed | output | 1 | Inactivity detector armed |
| act_flag | output | 1 | Activity interrupt flag |
| inact_flag | output | 1 | Inactivity interrupt flag |
| lowpwr_req | output | 1 | Request to enter wake-up mode |

## Verification
The hardest state to reach from the ports is a change of effective mode that lands while a flag is pending and a trigger is arriving in the same cycle. The R9 clearing only shows when a flag is already set and a trigger is held across the transition cycle. The stimulus first leaves an activity flag standing in the free-running mode. It then switches the field to linked while holding the activity trigger, and checks that the flag comes out cleared rather than set again. The looped one-cycle pulse is reached the same way: the checks sample on the cycle of the flag and on the cycle after it, where the opposite detector must be armed.

// File: rtl/actlink_pkg.sv
package actlink_pkg;

  typedef enum logic [1:0] {
    EM_DEFAULT = 2'd0,
    EM_LINKED  = 2'd1,
    EM_LOOPED  = 2'd2
  } eff_mode_e;

  // Effective mode: alternating modes need both detector classes enabled.
  function automatic eff_mode_e resolve_mode(input logic [1:0] field,
                                             input logic any_act,
                                             input logic any_inact);
    if (!(any_act && any_inact)) return EM_DEFAULT;
    case (field)
      2'b01:   return EM_LINKED;
      2'b10:   return EM_LOOPED;
      default: return EM_DEFAULT;
    endcase
  endfunction

  // Sticky flag: set wins over a concurrent host read.
  function automatic logic held_flag_next(input logic flag,
                                          input logic rd,
                                          input logic acc);
    return (flag & ~rd) | acc;
  endfunction

endpackage

// File: rtl/actlink_mode_dec.sv
module actlink_mode_dec
  import actlink_pkg::*;
#(
  parameter int NAXES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_field,
  input  logic [NAXES-1:0] act_en,
  input  logic [NAXES-1:0] inact_en,
  output eff_mode_e        eff_mode,
  output logic             mode_chg
);

  eff_mode_e prev_mode;

  assign eff_mode = resolve_mode(mode_field, |act_en, |inact_en);
  assign mode_chg = (eff_mode != prev_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_mode <= EM_DEFAULT;
    else        prev_mode <= eff_mode;
  end

endmodule

// File: rtl/actlink_seq.sv
module actlink_seq
  import actlink_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  eff_mode_e eff_mode,
  input  logic      mode_chg,
  input  logic      accept_any,
  input  logic      link_ack,
  output logic      sel_inact,
  output logic      loop_busy
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_inact <= 1'b0;
      loop_busy <= 1'b0;
    end else if (mode_chg) begin
      sel_inact <= 1'b0;
      loop_busy <= 1'b0;
    end else begin
      case (eff_mode)
        EM_LOOPED: begin
          if (loop_busy) begin
            loop_busy <= 1'b0;
            sel_inact <= ~sel_inact;
          end else if (accept_any) begin
            loop_busy <= 1'b1;
          end
        end
        EM_LINKED: begin
          loop_busy <= 1'b0;
          if (link_ack) sel_inact <= ~sel_inact;
        end
        default: begin
          sel_inact <= 1'b0;
          loop_busy <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/actlink_flags.sv
module actlink_flags
  import actlink_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  eff_mode_e eff_mode,
  input  logic      mode_chg,
  input  logic      status_rd,
  input  logic      autosleep,
  input  logic      act_acc,
  input  logic      inact_acc,
  output logic      act_flag,
  output logic      inact_flag,
  output logic      lowpwr_req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_flag   <= 1'b0;
      inact_flag <= 1'b0;
    end else if (mode_chg) begin
      act_flag   <= 1'b0;
      inact_flag <= 1'b0;
    end else if (eff_mode == EM_LOOPED) begin
      act_flag   <= act_acc;
      inact_flag <= inact_acc;
    end else begin
      act_flag   <= held_flag_next(act_flag, status_rd, act_acc);
      inact_flag <= held_flag_next(inact_flag, status_rd, inact_acc);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                           lowpwr_req <= 1'b0;
    else if (mode_chg || eff_mode == EM_DEFAULT || !autosleep) lowpwr_req <= 1'b0;
    else if (act_acc)                                     lowpwr_req <= 1'b0;
    else if (inact_acc)                                   lowpwr_req <= 1'b1;
  end

endmodule

// File: rtl/actlink_ctrl.sv
module actlink_ctrl
  import actlink_pkg::*;
#(
  parameter int NAXES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NAXES-1:0] act_axis_en,
  input  logic [NAXES-1:0] inact_axis_en,
  input  logic             act_hit,
  input  logic             inact_hit,
  input  logic [1:0]       proc_mode,
  input  logic             autosleep,
  input  logic             status_rd,
  output logic             act_armed,
  output logic             inact_armed,
  output logic             act_flag,
  output logic             inact_flag,
  output logic             lowpwr_req
);

  eff_mode_e eff_mode;
  logic      mode_chg;
  logic      sel_inact;
  logic      loop_busy;
  logic      link_pending;
  logic      act_acc;
  logic      inact_acc;
  logic      link_ack;

  actlink_mode_dec #(.NAXES(NAXES)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_field (proc_mode),
    .act_en     (act_axis_en),
    .inact_en   (inact_axis_en),
    .eff_mode   (eff_mode),
    .mode_chg   (mode_chg)
  );

  always_comb begin
    case (eff_mode)
      EM_LINKED: begin
        act_armed   = ~sel_inact;
        inact_armed = sel_inact;
      end
      EM_LOOPED: begin
        act_armed   = ~sel_inact & ~loop_busy;
        inact_armed = sel_inact & ~loop_busy;
      end
      default: begin
        act_armed   = |act_axis_en;
        inact_armed = |inact_axis_en;
      end
    endcase
  end

  assign link_pending = (eff_mode == EM_LINKED) && (act_flag || inact_flag);
  assign act_acc      = act_hit & act_armed & ~link_pending & ~mode_chg;
  assign inact_acc    = inact_hit & inact_armed & ~link_pending & ~mode_chg;
  assign link_ack     = link_pending & status_rd & ~mode_chg;

  actlink_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .eff_mode   (eff_mode),
    .mode_chg   (mode_chg),
    .accept_any (act_acc | inact_acc),
    .link_ack   (link_ack),
    .sel_inact  (sel_inact),
    .loop_busy  (loop_busy)
  );

  actlink_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .eff_mode   (eff_mode),
    .mode_chg   (mode_chg),
    .status_rd  (status_rd),
    .autosleep  (autosleep),
    .act_acc    (act_acc),
    .inact_acc  (inact_acc),
    .act_flag   (act_flag),
    .inact_flag (inact_flag),
    .lowpwr_req (lowpwr_req)
  );

endmodule

// File: rtl/actlink_chk.sv
module actlink_chk
  import actlink_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input eff_mode_e eff_mode,
  input logic      mode_chg,
  input logic      status_rd,
  input logic      autosleep,
  input logic      act_hit,
  input logic      inact_hit,
  input logic      act_armed,
  input logic      inact_armed,
  input logic      act_flag,
  input logic      inact_flag,
  input logic      lowpwr_req
);

  p_armed_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_mode != EM_DEFAULT) |-> $onehot0({act_armed, inact_armed}));

  p_link_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_mode == EM_LINKED && !mode_chg && act_flag && !status_rd) |=> act_flag);

  p_loop_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_mode == EM_LOOPED && (act_flag || inact_flag)) |=> !(act_flag || inact_flag));

  p_wake_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_mode == EM_DEFAULT || !autosleep) |=> !lowpwr_req);

  p_wake_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lowpwr_req) |-> $past(inact_hit));

  p_flag_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_flag) |-> $past(act_hit));

endmodule

bind actlink_ctrl actlink_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .eff_mode    (eff_mode),
  .mode_chg    (mode_chg),
  .status_rd   (status_rd),
  .autosleep   (autosleep),
  .act_hit     (act_hit),
  .inact_hit   (inact_hit),
  .act_armed   (act_armed),
  .inact_armed (inact_armed),
  .act_flag    (act_flag),
  .inact_flag  (inact_flag),
  .lowpwr_req  (lowpwr_req)
);

// File: tb/sim_actlink_ctrl.sv
module sim_actlink_ctrl;

  localparam int NAXES = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NAXES-1:0] act_axis_en = '0;
  logic [NAXES-1:0] inact_axis_en = '0;
  logic             act_hit = 1'b0;
  logic             inact_hit = 1'b0;
  logic [1:0]       proc_mode = 2'b00;
  logic             autosleep = 1'b0;
  logic             status_rd = 1'b0;
  logic             act_armed, inact_armed, act_flag, inact_flag, lowpwr_req;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  actlink_ctrl #(.NAXES(NAXES)) u0 (
    .clk(clk), .rst_n(rst_n), .act_axis_en(act_axis_en), .inact_axis_en(inact_axis_en),
    .act_hit(act_hit), .inact_hit(inact_hit), .proc_mode(proc_mode),
    .autosleep(autosleep), .status_rd(status_rd), .act_armed(act_armed),
    .inact_armed(inact_armed), .act_flag(act_flag), .inact_flag(inact_flag),
    .lowpwr_req(lowpwr_req)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Drive one trigger/strobe combination for one cycle.
  task automatic pulse(input logic a, input logic i, input logic rd);
    act_hit = a; inact_hit = i; status_rd = rd;
    tick();
    act_hit = 1'b0; inact_hit = 1'b0; status_rd = 1'b0;
  endtask

  task automatic t_reset();
    act_axis_en = 3'b100; inact_axis_en = 3'b010;
    repeat (2) @(negedge clk);
    chk("R1", "act_flag in reset", act_flag, 1'b0);
    rst_n = 1'b1;
    tick();
    chk("R1", "act_flag", act_flag, 1'b0);
    chk("R1", "inact_flag", inact_flag, 1'b0);
    chk("R1", "lowpwr_req", lowpwr_req, 1'b0);
    chk("R1", "act_armed", act_armed, 1'b1);
    chk("R1", "inact_armed", inact_armed, 1'b1);
  endtask

  task automatic t_default();
    autosleep = 1'b1;
    pulse(1'b1, 1'b0, 1'b0);
    chk("R2", "act_flag set", act_flag, 1'b1);
    tick();
    chk("R2", "act_flag held", act_flag, 1'b1);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R2", "inact_flag set", inact_flag, 1'b1);
    chk("R8", "no wake in free-running", lowpwr_req, 1'b0);
    pulse(1'b1, 1'b0, 1'b1);
    chk("R2", "act_flag survives read with hit", act_flag, 1'b1);
    chk("R2", "inact_flag cleared by read", inact_flag, 1'b0);
    pulse(1'b0, 1'b0, 1'b1);
    chk("R2", "act_flag cleared by read", act_flag, 1'b0);
  endtask

  task automatic t_mode11();
    proc_mode = 2'b11;
    tick();
    chk("R6", "act_armed", act_armed, 1'b1);
    chk("R6", "inact_armed", inact_armed, 1'b1);
    pulse(1'b1, 1'b0, 1'b0);
    tick();
    chk("R6", "act_flag persists", act_flag, 1'b1);
  endtask

  task automatic t_linked();
    // act_flag still pending from t_mode11; switch with a trigger held.
    proc_mode = 2'b01; act_hit = 1'b1;
    tick();
    act_hit = 1'b0;
    chk("R9", "act_flag cleared on mode change", act_flag, 1'b0);
    chk("R9", "activity armed first", act_armed, 1'b1);
    chk("R3", "inactivity not armed", inact_armed, 1'b0);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R3", "unarmed inact trigger ignored", inact_flag, 1'b0);
    pulse(1'b1, 1'b0, 1'b0);
    chk("R3", "act_flag set", act_flag, 1'b1);
    pulse(1'b1, 1'b1, 1'b0);
    chk("R3", "pending blocks inact", inact_flag, 1'b0);
    chk("R3", "still activity armed", act_armed, 1'b1);
    tick();
    chk("R3", "act_flag held", act_flag, 1'b1);
    pulse(1'b0, 1'b0, 1'b1);
    chk("R3", "read clears act_flag", act_flag, 1'b0);
    chk("R3", "read arms inactivity", inact_armed, 1'b1);
    chk("R3", "activity disarmed", act_armed, 1'b0);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R7", "inact_flag set", inact_flag, 1'b1);
    chk("R7", "wake request set", lowpwr_req, 1'b1);
    pulse(1'b0, 1'b0, 1'b1);
    chk("R3", "read clears inact_flag", inact_flag, 1'b0);
    chk("R7", "wake request held", lowpwr_req, 1'b1);
    chk("R3", "activity re-armed", act_armed, 1'b1);
    pulse(1'b1, 1'b0, 1'b0);
    chk("R7", "activity clears wake", lowpwr_req, 1'b0);
    pulse(1'b0, 1'b0, 1'b1);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R7", "wake set again", lowpwr_req, 1'b1);
    autosleep = 1'b0;
    tick();
    chk("R8", "autosleep off drops wake", lowpwr_req, 1'b0);
    autosleep = 1'b1;
    pulse(1'b0, 1'b0, 1'b1);
    chk("R3", "back to activity", act_armed, 1'b1);
  endtask

  task automatic t_looped();
    proc_mode = 2'b10;
    tick();
    chk("R9", "activity armed after change", act_armed, 1'b1);
    pulse(1'b1, 1'b0, 1'b0);
    chk("R4", "act_flag pulse", act_flag, 1'b1);
    chk("R4", "act disarmed during pulse", act_armed, 1'b0);
    chk("R4", "inact disarmed during pulse", inact_armed, 1'b0);
    pulse(1'b0, 1'b0, 1'b1);
    chk("R4", "act_flag self-cleared", act_flag, 1'b0);
    chk("R4", "opposite armed", inact_armed, 1'b1);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R4", "inact_flag pulse", inact_flag, 1'b1);
    chk("R7", "wake set in loop", lowpwr_req, 1'b1);
    tick();
    chk("R4", "inact_flag self-cleared", inact_flag, 1'b0);
    chk("R7", "wake held", lowpwr_req, 1'b1);
    chk("R4", "activity re-armed", act_armed, 1'b1);
    pulse(1'b1, 1'b0, 1'b0);
    chk("R7", "activity clears wake in loop", lowpwr_req, 1'b0);
    tick();
  endtask

  task automatic t_fallback();
    inact_axis_en = '0;
    tick();
    chk("R5", "activity armed", act_armed, 1'b1);
    chk("R5", "inactivity not armed", inact_armed, 1'b0);
    pulse(1'b1, 1'b0, 1'b0);
    tick();
    chk("R5", "flag sticky, not looped", act_flag, 1'b1);
    chk("R8", "no wake when fallen back", lowpwr_req, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_default();
    t_mode11();
    t_linked();
    t_looped();
    t_fallback();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule